// File: doc/BRIEF.md
# Burst Flash Read Sequencer

This block sits on the host side of a burst-capable NOR flash. It turns one request into one complete burst read. The request carries a start address and a first-access latency. The block raises chip enable and output enable, and drives the load-address strobe over the first flash clock rise. It then counts the programmed number of flash clock rises until the first word is ready. After that it holds the advance strobe low while the device steps through the following words.

The flash clock runs at half the controller clock. Every word is captured one controller cycle after the flash clock rise that presents it, and is handed out with a one-cycle valid pulse. The device's end-of-burst indicator is checked against the block's own word count, which is 32 words. A mismatch in either direction ends the burst with an error flag. When the burst ends, all strobes return high and a one-cycle done pulse is given.

Top module: `burst_read_seq`

## Requirements
- R1: During and right after reset, all four flash strobes are high, the flash clock is low, and busy, rd_valid, done and seq_err are low.
- R2: go is sampled while idle. On the next cycle, ce_n, oe_n and lba_n are low and fl_addr equals start_addr. The flash clock rises one cycle later with lba_n still low. On the following cycle lba_n is high, before the next rise.
- R3: ce_n and oe_n stay low together on every cycle from the load cycle until the cycle in which done is raised.
- R4: While busy, the flash clock toggles on every controller cycle. While idle, it is low.
- R5: init_lat is sampled at go and counts flash clock rises after the load rise. The first word is captured 2+2·L cycles after the go edge. Values 0 and 1 are treated as 2; the legal maximum is 15.
- R6: baa_n is high until the first word is captured. It is low from then until the burst ends.
- R7: Each word is captured one controller cycle after a flash clock rise, with rd_valid high for exactly one cycle. Words follow every two cycles in device order.
- R8: If fl_ind_n is low on the 32nd word, done pulses together with that word's rd_valid and seq_err stays low. The strobes are high and busy is low from that cycle on.
- R9: If fl_ind_n is low on word k with k < 32, the burst ends at word k, with done and seq_err high on that word.
- R10: If fl_ind_n is still high on the 32nd word, the burst ends there with done and seq_err high.
- R11: go raised while busy has no effect. The burst in progress is unchanged, and no new burst starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, sampled while idle |
| start_addr | input | 20 | Initial burst word address |
| init_lat | input | 4 | Flash clock rises to the first word |
| busy | output | 1 | Burst in progress |
| fl_clk | output | 1 | Flash clock, half the controller rate |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_lba_n | output | 1 | Load start address strobe, active low |
| fl_baa_n | output | 1 | Burst advance strobe, active low |
| fl_addr | output | 20 | Address bus to the flash |
| fl_dq | input | 16 | Read data from the flash |
| fl_ind_n | input | 1 | End-of-burst indicator, active low |
| rd_data | output | 16 | Captured word |
| rd_valid | output | 1 | One-cycle pulse per captured word |
| done | output | 1 | One-cycle pulse at burst end |
| seq_err | output | 1 | Indicator mismatch, valid with done |

## Verification
The hardest cases to reach are the indicator disagreeing with the word count, and a go arriving in the middle of a burst. A model of the flash in the bench presents the words and lowers its indicator at a word position chosen per vector. The positions are: the last word, an early word, the very first word, and never. The model releases the first word only after the programmed number of rises. A capture that comes too early therefore returns a poison value, and one that comes too late shows up as a wrong capture cycle. One directed burst pulses go with a different address halfway through. It then checks that the words still follow the first address and that the block goes idle afterwards.

// File: rtl/burst_read_pkg.sv
package burst_read_pkg;

    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 16;
    localparam int BURST_LEN  = 32;
    localparam int LAT_W      = 4;
    localparam int LAT_MIN    = 2;
    localparam int WCNT_W     = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_LAT    = 2'd2,
        ST_STREAM = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic lba_n;
        logic baa_n;
    } strobe_t;

    localparam strobe_t STROBES_OFF = '{ce_n: 1'b1, oe_n: 1'b1, lba_n: 1'b1, baa_n: 1'b1};

    function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] raw);
        if (raw < LAT_W'(LAT_MIN))
            return LAT_W'(LAT_MIN);
        return raw;
    endfunction

endpackage

// File: rtl/burst_fclk_gen.sv
module burst_fclk_gen (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic fclk,
    output logic rise_evt,
    output logic fall_evt
);
    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= 1'b0;
        else if (run)
            ph_q <= ~ph_q;
        else
            ph_q <= 1'b0;
    end

    assign fclk     = ph_q;
    assign rise_evt = run && !ph_q;
    assign fall_evt = run && ph_q;

    AST_FCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(rst)) |-> (ph_q != $past(ph_q))); // R4

endmodule

// File: rtl/burst_lat_timer.sv
module burst_lat_timer
    import burst_read_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LAT_W-1:0] lat_in,
    input  logic             count_en,
    output logic             hit
);
    logic [LAT_W-1:0] lat_q;
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= LAT_W'(LAT_MIN);
            cnt_q <= '0;
        end else if (start) begin
            lat_q <= clamp_lat(lat_in);
            cnt_q <= '0;
        end else if (count_en && cnt_q != lat_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = (cnt_q == lat_q);

    AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        hit |-> (cnt_q >= LAT_W'(LAT_MIN))); // R5

endmodule

// File: rtl/burst_word_track.sv
module burst_word_track
    import burst_read_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cap,
    input  logic ind_n,
    output logic fin,
    output logic err
);
    localparam logic [WCNT_W-1:0] LAST_IDX = WCNT_W'(BURST_LEN - 1);

    logic [WCNT_W-1:0] wcnt_q;
    logic              at_last;

    always_ff @(posedge clk) begin
        if (rst)
            wcnt_q <= '0;
        else if (start)
            wcnt_q <= '0;
        else if (cap && !fin)
            wcnt_q <= wcnt_q + 1'b1;
    end

    assign at_last = (wcnt_q == LAST_IDX);
    assign fin     = cap && (at_last || !ind_n);
    assign err     = cap && (at_last ? ind_n : !ind_n);

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        (cap && !fin && !start) |=> (wcnt_q == $past(wcnt_q) + 1'b1)); // R7

    AST_EARLY_IND_ERR: assert property (@(posedge clk) disable iff (rst)
        (cap && !ind_n && !at_last) |-> (fin && err)); // R9

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import burst_read_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LAT_W-1:0]  init_lat,
    output logic              busy,
    output logic              fl_clk,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_lba_n,
    output logic              fl_baa_n,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_dq,
    input  logic              fl_ind_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              seq_err
);
    seq_state_t        state_q;
    strobe_t           stb_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q, done_q, err_q;

    logic run, rise_evt, fall_evt, fclk_w;
    logic start, lat_hit, cap, fin, werr;

    assign run   = (state_q != ST_IDLE);
    assign start = (state_q == ST_IDLE) && go;
    assign cap   = fall_evt && ((state_q == ST_STREAM) || (state_q == ST_LAT && lat_hit));

    burst_fclk_gen u_fclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .fclk     (fclk_w),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    burst_lat_timer u_lat (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .lat_in   (init_lat),
        .count_en (rise_evt && state_q == ST_LAT),
        .hit      (lat_hit)
    );

    burst_word_track u_track (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .cap   (cap),
        .ind_n (fl_ind_n),
        .fin   (fin),
        .err   (werr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            stb_q   <= STROBES_OFF;
            addr_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        state_q    <= ST_LOAD;
                        addr_q     <= start_addr;
                        stb_q.ce_n  <= 1'b0;
                        stb_q.oe_n  <= 1'b0;
                        stb_q.lba_n <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (fall_evt) begin
                        stb_q.lba_n <= 1'b1;
                        state_q     <= ST_LAT;
                    end
                end
                ST_LAT: begin
                    if (cap) begin
                        stb_q.baa_n <= 1'b0;
                        state_q     <= ST_STREAM;
                    end
                end
                default: ;
            endcase
            if (cap) begin
                data_q  <= fl_dq;
                valid_q <= 1'b1;
                if (fin) begin
                    state_q <= ST_IDLE;
                    stb_q   <= STROBES_OFF;
                    done_q  <= 1'b1;
                    err_q   <= werr;
                end
            end
        end
    end

    assign busy     = run;
    assign fl_clk   = fclk_w;
    assign fl_ce_n  = stb_q.ce_n;
    assign fl_oe_n  = stb_q.oe_n;
    assign fl_lba_n = stb_q.lba_n;
    assign fl_baa_n = stb_q.baa_n;
    assign fl_addr  = addr_q;
    assign rd_data  = data_q;
    assign rd_valid = valid_q;
    assign done     = done_q;
    assign seq_err  = err_q;

    AST_LBA_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!fl_lba_n && fl_clk) |=> fl_lba_n); // R2
    AST_CE_OE_PAIR: assert property (@(posedge clk) disable iff (rst)
        fl_ce_n == fl_oe_n); // R3
    AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !fl_clk); // R4
    AST_BAA_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        !fl_baa_n |-> (fl_lba_n && !fl_ce_n)); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R7
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_valid && !busy && fl_ce_n && fl_lba_n && fl_baa_n)); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> done); // R10

endmodule

// File: tb/burst_read_seq_tb.sv
module burst_read_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int LAT_T [NV] = '{2, 5, 15, 3, 4, 0, 1, 7};
    localparam int IND_T [NV] = '{31, 31, 31, 9, 99, 31, 31, 0};
    localparam int ADR_T [NV] = '{32'h00100, 32'hABCDE, 32'h7FFF0, 32'h01234,
                                  32'h55555, 32'h00042, 32'hFFFF8, 32'h33333};
    localparam int NW_T  [NV] = '{32, 32, 32, 10, 32, 32, 32, 1};
    localparam int ER_T  [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [19:0] start_addr = '0;
    logic [3:0]  init_lat = '0;
    logic        busy, fl_clk, fl_ce_n, fl_oe_n, fl_lba_n, fl_baa_n;
    logic [19:0] fl_addr;
    logic [15:0] fl_dq = 16'hDEAD;
    logic        fl_ind_n = 1'b1;
    logic [15:0] rd_data;
    logic        rd_valid, done, seq_err;

    int checks = 0;
    int fails = 0;
    int wd = 0;

    int m_lat = 2;
    int m_ind = 31;
    int m_rise = 0;
    int m_idx = 0;
    bit m_on = 1'b0;
    logic [19:0] m_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_read_seq dut_i (
        .clk(clk), .rst(rst), .go(go), .start_addr(start_addr), .init_lat(init_lat),
        .busy(busy), .fl_clk(fl_clk), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_lba_n(fl_lba_n), .fl_baa_n(fl_baa_n), .fl_addr(fl_addr), .fl_dq(fl_dq),
        .fl_ind_n(fl_ind_n), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .seq_err(seq_err)
    );

    function automatic logic [15:0] wfn(input logic [19:0] a, input int i);
        return (a[15:0] + 16'(i)) ^ 16'h5A3C;
    endfunction

    // flash device model
    always @(posedge fl_clk) begin
        if (!fl_ce_n && !fl_lba_n) begin
            m_addr   <= fl_addr;
            m_rise   <= 0;
            m_idx    <= 0;
            m_on     <= 1'b1;
            fl_dq    <= 16'hDEAD;
            fl_ind_n <= 1'b1;
        end else if (m_on && !fl_ce_n) begin
            if (m_rise < m_lat) begin
                m_rise <= m_rise + 1;
                if (m_rise + 1 == m_lat) begin
                    fl_dq    <= wfn(m_addr, 0);
                    fl_ind_n <= (m_ind == 0) ? 1'b0 : 1'b1;
                end
            end else if (!fl_baa_n) begin
                m_idx    <= m_idx + 1;
                fl_dq    <= wfn(m_addr, m_idx + 1);
                fl_ind_n <= (m_ind == m_idx + 1) ? 1'b0 : 1'b1;
            end
        end
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", wd, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic run_burst(input int lat, input int ind, input int adr,
                             input int nw, input int er, input bit inject);
        int dev, cyc, words, bad_ce, bad_baa, bad_clk;
        bit fin;
        logic prev_clk;
        dev = (lat < 2) ? 2 : lat;
        @(negedge clk);
        start_addr = adr[19:0];
        init_lat   = lat[3:0];
        m_lat      = dev;
        m_ind      = ind;
        go         = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        cyc = 0;
        chk("R2 load cycle strobes/address",
            !fl_ce_n && !fl_oe_n && !fl_lba_n && fl_addr == adr[19:0] && !fl_clk,
            {fl_ce_n, fl_oe_n, fl_lba_n, fl_clk}, 0);
        words = 0; bad_ce = 0; bad_baa = 0; bad_clk = 0; fin = 1'b0;
        prev_clk = fl_clk;
        while (!fin && cyc < 300) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 1) chk("R2 lba held over load rise", !fl_lba_n && fl_clk, {fl_lba_n, fl_clk}, 1);
            if (cyc == 2) chk("R2 lba released before next rise", fl_lba_n && !fl_clk, {fl_lba_n, fl_clk}, 2);
            if (inject && cyc == 10) begin go = 1'b1; start_addr = 20'h0F0F0; init_lat = 4'd9; end
            if (inject && cyc == 11) go = 1'b0;
            if (done && !rd_valid) chk("R8 done without word", 1'b0, 0, 1);
            if (rd_valid) begin
                if (words == 0)
                    chk("R5 first word capture cycle", cyc == 2 + 2*dev, cyc, 2 + 2*dev);
                else if (cyc != 2 + 2*dev + 2*words)
                    chk("R7 word spacing", 1'b0, cyc, 2 + 2*dev + 2*words);
                chk("R7 word data", rd_data == wfn(adr[19:0], words), rd_data, wfn(adr[19:0], words));
                words++;
                if (done) begin
                    fin = 1'b1;
                    chk("R9 R10 word count at done", words == nw, words, nw);
                    chk("R8 R9 R10 seq_err at done", seq_err == er[0], seq_err, er);
                    chk("R8 strobes high at done", fl_ce_n && fl_oe_n && fl_lba_n && fl_baa_n && !busy,
                        {fl_ce_n, fl_oe_n, fl_lba_n, fl_baa_n, busy}, 5'h1E);
                end
            end
            if (!fin) begin
                if (fl_ce_n || fl_oe_n) bad_ce++;
                if ((words > 0) == fl_baa_n) bad_baa++;
                if (fl_clk == prev_clk) bad_clk++;
                prev_clk = fl_clk;
            end
        end
        chk("R7 burst finished", fin, cyc, 2 + 2*dev + 2*(nw-1));
        chk("R3 ce/oe held low", bad_ce == 0, bad_ce, 0);
        chk("R6 baa timing", bad_baa == 0, bad_baa, 0);
        chk("R4 flash clock toggles", bad_clk == 0, bad_clk, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R11 R8 idle after burst", !busy && fl_ce_n && !fl_clk && !done && !rd_valid,
                {busy, fl_ce_n, fl_clk}, 3'b010);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 reset strobes", fl_ce_n && fl_oe_n && fl_lba_n && fl_baa_n && !fl_clk,
            {fl_ce_n, fl_oe_n, fl_lba_n, fl_baa_n, fl_clk}, 5'h1E);
        chk("R1 reset status", !busy && !rd_valid && !done && !seq_err,
            {busy, rd_valid, done, seq_err}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", !busy && fl_ce_n && !fl_clk, {busy, fl_ce_n, fl_clk}, 3'b010);

        for (int v = 0; v < NV; v++)
            run_burst(LAT_T[v], IND_T[v], ADR_T[v], NW_T[v], ER_T[v], 1'b0);

        // R11: go pulsed mid-burst with a different address and latency
        run_burst(6, 31, 32'h2468A, 32, 0, 1'b1);

        // R5: top of the legal latency range back-to-back with the floor
        run_burst(15, 9, 32'h11111, 10, 1, 1'b0);
        run_burst(2, 31, 32'h22222, 32, 0, 1'b0);

        // R1: reset mid-burst returns everything to idle
        @(negedge clk);
        start_addr = 20'h01010; init_lat = 4'd4; m_lat = 4; m_ind = 31; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-burst", !busy && fl_ce_n && fl_oe_n && fl_lba_n && fl_baa_n && !fl_clk,
            {busy, fl_ce_n, fl_oe_n, fl_lba_n, fl_baa_n, fl_clk}, 6'h1E);
        rst = 1'b0;
        @(negedge clk);
        run_burst(3, 31, 32'h0ACE1, 32, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule